// File: doc/BRIEF.md
# I2C Master Command Queue

This block is the host-side front end of an I2C master controller. Software talks to it through a small register window. A single command/data register accepts queued entries. Each entry is either a byte to transmit or a request to receive one byte, and either kind can be marked to close the transfer with a STOP. Reading the same register returns received bytes, oldest first.

Entries leave a transmit queue one at a time toward a byte-level bus engine, which handles the SCL/SDA bit timing and lives outside this block. The engine accepts an entry with a valid/ready handshake and later pulses a completion. For a receive request it returns the byte with that pulse, and the byte is stored in a receive queue.

A status register shows queue occupancy, master activity and bus idleness. A raw interrupt register holds a stop-detected flag and a sticky overflow flag. The stop-detected flag also drives an interrupt output and is cleared by reading a dedicated clear register.

Top module: `i2c_cmd_queue`

## Requirements
- R1: A write to register 0 while the transmit queue is not full stores one entry with data in bits[7:0], a receive-request flag in bit 8 and a STOP flag in bit 9. Entries are offered on `eng_cmd` in write order, each exactly once, so duplicate receive-request writes give duplicate bus reads. `eng_req` is high only while the queue holds an entry.
- R2: A write to register 0 while the transmit queue holds DEPTH entries is discarded and sets bit 1 of register 2 (overflow). The flag stays set until reset, and the discarded entry never reaches the engine.
- R3: Completion of a receive request stores `eng_rbyte` in the receive queue. A read of register 0 returns the oldest byte in bits[7:0] and removes it. A read of register 0 with the receive queue empty returns 0 and changes nothing.
- R4: A receive-request entry at the head of the transmit queue is not offered while the receive queue holds DEPTH bytes. It is offered once a byte has been read out.
- R5: Register 1 bits are: bit 0 master active, bit 1 transmit queue not full, bit 2 transmit queue empty, bit 3 receive queue not empty, bit 4 bus idle. All other bits read 0.
- R6: Master active is set the cycle after the engine accepts an entry. It clears on completion of an entry whose STOP flag is set. That same completion sets the stop-detected flag (register 2 bit 0 and `stop_irq`).
- R7: A read of register 3 returns the stop-detected flag in bit 0 and clears the flag, unless a STOP completion sets it in the same cycle.
- R8: Only one entry is outstanding at the engine. `eng_req` stays low from acceptance until the completion pulse.
- R9: After reset, register 1 reads 0x16, register 2 reads 0, and `eng_req` and `stop_irq` are low.
- R10: Bus idle (register 1 bit 4) is high exactly when master activity is clear and the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register select: 0 cmd/data, 1 status, 2 raw interrupt, 3 stop clear |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Read data for the selected register, combinational |
| eng_req | output | 1 | Entry offered to the bus engine |
| eng_cmd | output | 10 | Offered entry: {stop, read, data} |
| eng_ready | input | 1 | Engine accepts the offered entry |
| eng_done | input | 1 | Engine completion pulse for the outstanding entry |
| eng_rbyte | input | 8 | Byte received by the engine, valid with eng_done |
| stop_irq | output | 1 | Stop-detected interrupt level |

## Verification
The bench builds the block with the default DEPTH of 8. With that depth, eight queued entries fill the transmit queue and eight receive completions fill the receive queue. The overflow drop and the receive-full hold are therefore reached with short directed sequences. The random traffic also runs into full queues often, which exercises back-pressure between host pops, engine completions and new writes.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              stop;
        logic              rd;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [1:0] {
        A_DATA   = 2'd0,
        A_STATUS = 2'd1,
        A_RAW    = 2'd2,
        A_CLEAR  = 2'd3
    } reg_addr_e;

    localparam int ST_ACTIVE = 0;
    localparam int ST_TXNF   = 1;
    localparam int ST_TXE    = 2;
    localparam int ST_RXNE   = 3;
    localparam int ST_IDLE   = 4;
    localparam int ST_W      = 5;

    localparam int RAW_STOP = 0;
    localparam int RAW_OVF  = 1;

    typedef enum logic {
        SQ_READY,
        SQ_WAIT
    } seq_e;

    function automatic logic [CMD_W-1:0] widen_byte(input logic [BYTE_W-1:0] b);
        return {{(CMD_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign head    = mem[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
    import i2cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              tx_head,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              eng_ready,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_rbyte,
    output logic              eng_req,
    output cmd_t              eng_cmd,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_din,
    output logic              active,
    output logic              stop_set
);
    seq_e st;
    logic cur_rd, cur_stop;
    logic fin;

    // a receive request waits while there is no room for its byte
    assign eng_req  = (st == SQ_READY) && !tx_empty && !(tx_head.rd && rx_full);
    assign eng_cmd  = tx_head;
    assign tx_pop   = eng_req && eng_ready;
    assign fin      = (st == SQ_WAIT) && eng_done;
    assign rx_push  = fin && cur_rd;
    assign rx_din   = eng_rbyte;
    assign stop_set = fin && cur_stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_READY;
            cur_rd   <= 1'b0;
            cur_stop <= 1'b0;
            active   <= 1'b0;
        end else if (tx_pop) begin
            st       <= SQ_WAIT;
            cur_rd   <= tx_head.rd;
            cur_stop <= tx_head.stop;
            active   <= 1'b1;
        end else if (fin) begin
            st <= SQ_READY;
            if (cur_stop) active <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cq_regs.sv
module i2cq_regs
    import i2cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              rx_empty,
    input  logic [BYTE_W-1:0] rx_head,
    input  logic              active,
    input  logic              stop_set,
    output logic              tx_push,
    output cmd_t              tx_din,
    output logic              rx_pop,
    output logic [CMD_W-1:0]  reg_rdata,
    output logic              stop_det,
    output logic              ovf
);
    reg_addr_e   sel;
    logic        wr_data, clr_stop;
    logic [ST_W-1:0] status;

    assign sel      = reg_addr_e'(reg_addr);
    assign wr_data  = reg_wr && (sel == A_DATA);
    assign tx_push  = wr_data && !tx_full;
    assign tx_din   = cmd_t'(reg_wdata);
    assign rx_pop   = reg_rd && (sel == A_DATA) && !rx_empty;
    assign clr_stop = reg_rd && (sel == A_CLEAR);

    always_comb begin
        status            = '0;
        status[ST_ACTIVE] = active;
        status[ST_TXNF]   = !tx_full;
        status[ST_TXE]    = tx_empty;
        status[ST_RXNE]   = !rx_empty;
        status[ST_IDLE]   = !active && tx_empty;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            A_DATA:   reg_rdata = rx_empty ? '0 : widen_byte(rx_head);
            A_STATUS: reg_rdata[ST_W-1:0] = status;
            A_RAW: begin
                reg_rdata[RAW_STOP] = stop_det;
                reg_rdata[RAW_OVF]  = ovf;
            end
            A_CLEAR:  reg_rdata[RAW_STOP] = stop_det;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_det <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            if (wr_data && tx_full) ovf <= 1'b1;
            if (stop_set)           stop_det <= 1'b1;
            else if (clr_stop)      stop_det <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_cmd_queue.sv
module i2c_cmd_queue
    import i2cq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [CMD_W-1:0]  reg_rdata,
    output logic              eng_req,
    output logic [CMD_W-1:0]  eng_cmd,
    input  logic              eng_ready,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_rbyte,
    output logic              stop_irq
);
    cmd_t              tx_din, tx_head, eng_cmd_s;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic [BYTE_W-1:0] rx_din, rx_head;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic              active, stop_set, ovf;

    i2cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .din(tx_din), .pop(tx_pop),
        .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    i2cq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_din), .pop(rx_pop),
        .head(rx_head), .full(rx_full), .empty(rx_empty)
    );

    i2cq_seq u_seq (
        .clk(clk), .rst(rst),
        .tx_head(tx_head), .tx_empty(tx_empty), .rx_full(rx_full),
        .eng_ready(eng_ready), .eng_done(eng_done), .eng_rbyte(eng_rbyte),
        .eng_req(eng_req), .eng_cmd(eng_cmd_s), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_din(rx_din),
        .active(active), .stop_set(stop_set)
    );

    i2cq_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_empty(rx_empty), .rx_head(rx_head),
        .active(active), .stop_set(stop_set),
        .tx_push(tx_push), .tx_din(tx_din), .rx_pop(rx_pop),
        .reg_rdata(reg_rdata), .stop_det(stop_irq), .ovf(ovf)
    );

    assign eng_cmd = eng_cmd_s;

endmodule

// File: rtl/i2cq_checker.sv
module i2cq_checker (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic       eng_req,
    input logic       eng_ready,
    input logic       eng_done,
    input logic       eng_cmd_rd,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       rx_full,
    input logic       active,
    input logic       ovf,
    input logic       stop_irq
);
    // R8: nothing is offered in the cycle after an acceptance
    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_ready) |=> !eng_req);

    // R6: activity follows acceptance
    p_active_on_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_ready) |=> active);

    // R6: stop detection coincides with end of activity
    p_stop_ends_active_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_irq) |-> $fell(active));

    // R1: an offer always has an entry behind it
    p_req_has_entry_r1: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> !tx_empty);

    // R2: write into a full queue raises overflow
    p_overflow_set_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && tx_full) |=> ovf);

    // R2: overflow is sticky
    p_overflow_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R7: clear read drops the flag when no completion competes
    p_clear_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd3 && !eng_done) |=> !stop_irq);

    // R4: no receive request offered while the receive queue is full
    p_rx_hold_r4: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> !(eng_cmd_rd && rx_full));

endmodule

bind i2c_cmd_queue i2cq_checker u_chk (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .eng_req(eng_req), .eng_ready(eng_ready), .eng_done(eng_done),
    .eng_cmd_rd(eng_cmd[8]),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full),
    .active(active), .ovf(ovf), .stop_irq(stop_irq)
);

// File: tb/i2c_cmd_queue_bench.sv
module i2c_cmd_queue_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd1;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic       eng_req;
    logic [9:0] eng_cmd;
    logic       eng_ready = 1'b1;
    logic       eng_done = 1'b0;
    logic [7:0] eng_rbyte = '0;
    logic       stop_irq;

    always #10 clk = ~clk;

    i2c_cmd_queue #(.DEPTH(8)) u_i2c_cmd_queue (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_ready(eng_ready),
        .eng_done(eng_done), .eng_rbyte(eng_rbyte), .stop_irq(stop_irq)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [9:0] exp_cmd [1024];
    logic [9:0] got_cmd [1024];
    logic [7:0] exp_rx  [1024];
    int n_exp = 0, n_got = 0, n_exprx = 0, n_rxrd = 0;

    bit pend = 0;
    int cd = 0;

    function automatic logic [7:0] eng_byte(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    // engine model: acts a little after each falling edge
    always @(negedge clk) begin
        #4;
        if (eng_done) eng_done = 1'b0;
        if (rst) begin
            pend = 0;
        end else if (pend) begin
            if (cd == 0) begin
                eng_done  = 1'b1;
                eng_rbyte = eng_byte(n_got - 1);
                pend      = 0;
            end else begin
                cd--;
            end
        end else if (eng_req && eng_ready) begin
            got_cmd[n_got] = eng_cmd;
            n_got++;
            pend = 1;
            cd   = $urandom_range(0, 3);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, input bit side, output logic [9:0] v);
        reg_addr = a;
        reg_rd   = side;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd   = 1'b0;
        reg_addr = 2'd1;
    endtask

    task automatic wr_reg(input logic [9:0] v);
        reg_addr  = 2'd0;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 2'd1;
    endtask

    task automatic push_cmd(input logic [9:0] v, output bit ok);
        logic [9:0] s;
        rd_reg(2'd1, 0, s);
        ok = s[1];
        if (ok) begin
            wr_reg(v);
            exp_cmd[n_exp] = v;
            if (v[8]) begin
                exp_rx[n_exprx] = eng_byte(n_exp);
                n_exprx++;
            end
            n_exp++;
        end
    endtask

    task automatic pop_check(input string tag);
        logic [9:0] v;
        rd_reg(2'd0, 1, v);
        chk(tag, int'(v), int'(exp_rx[n_rxrd]));
        n_rxrd++;
    endtask

    // push, draining received bytes when the queue is full
    task automatic push_force(input logic [9:0] v);
        bit ok;
        logic [9:0] s;
        for (int i = 0; i < 400; i++) begin
            push_cmd(v, ok);
            if (ok) break;
            rd_reg(2'd1, 0, s);
            if (s[3]) pop_check("R3 drain pop");
        end
    endtask

    task automatic drain_idle();
        logic [9:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(2'd1, 0, s);
            if (s[3]) pop_check("R3 drain pop");
            else if (s[4] && !pend && !eng_done) break;
        end
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] v;
        bit ok;
        int base;
        void'($urandom(32'd4711));

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd_reg(2'd1, 0, v); chk("R9 status after reset", int'(v), 'h16);
        rd_reg(2'd2, 0, v); chk("R9 raw after reset", int'(v), 0);
        chk("R9 eng_req after reset", int'(eng_req), 0);
        chk("R9 stop_irq after reset", int'(stop_irq), 0);

        // R1 / R6 / R10: a write then a write with STOP
        push_cmd(10'h0A5, ok);
        push_cmd(10'h23C, ok);
        drain_idle();
        rd_reg(2'd2, 0, v); chk("R6 stop detected bit", int'(v[0]), 1);
        chk("R6 stop_irq level", int'(stop_irq), 1);
        rd_reg(2'd1, 0, v);
        chk("R6 activity cleared after STOP", int'(v[0]), 0);
        chk("R10 bus idle", int'(v[4]), 1);
        chk("R5 status idle pattern", int'(v), 'h16);

        // R7 clear by read
        rd_reg(2'd3, 1, v); chk("R7 clear returns flag", int'(v[0]), 1);
        rd_reg(2'd2, 0, v); chk("R7 flag cleared", int'(v[0]), 0);
        chk("R7 stop_irq low", int'(stop_irq), 0);
        rd_reg(2'd3, 1, v); chk("R7 second clear reads 0", int'(v), 0);

        // R1 duplicates, R3 read data
        push_cmd(10'h100, ok);
        push_cmd(10'h100, ok);
        push_cmd(10'h100, ok);
        push_cmd(10'h300, ok);
        drain_idle();
        rd_reg(2'd1, 0, v); chk("R5 rx not empty after reads", int'(v[3]), 0);
        rd_reg(2'd0, 1, v); chk("R3 empty pop returns 0", int'(v), 0);
        rd_reg(2'd1, 0, v); chk("R3 empty pop no effect", int'(v), 'h16);

        // R2 overflow with the engine held
        eng_ready = 1'b0;
        for (int i = 0; i < 8; i++) push_cmd(10'(((i == 7) ? 10'h200 : 10'h000) | 10'(i + 8'h40)), ok);
        rd_reg(2'd1, 0, v);
        chk("R5 tx full clears not-full", int'(v[1]), 0);
        chk("R5 tx full clears empty", int'(v[2]), 0);
        wr_reg(10'h0FF);
        rd_reg(2'd2, 0, v); chk("R2 overflow set", int'(v[1]), 1);
        eng_ready = 1'b1;
        drain_idle();
        rd_reg(3'd2, 0, v); chk("R2 overflow sticky", int'(v[1]), 1);
        rd_reg(2'd3, 1, v);

        // R4 receive-full hold
        for (int i = 0; i < 8; i++) push_cmd(10'h100, ok);
        repeat (60) @(negedge clk);
        rd_reg(2'd1, 0, v); chk("R5 tx drained", int'(v[2]), 1);
        push_cmd(10'h300, ok);
        base = n_got;
        repeat (30) @(negedge clk);
        chk("R4 request held while rx full", n_got, base);
        rd_reg(2'd1, 0, v); chk("R4 entry still queued", int'(v[2]), 0);
        pop_check("R4 pop frees room");
        repeat (20) @(negedge clk);
        chk("R4 request issued after pop", n_got, base + 1);
        drain_idle();
        rd_reg(2'd3, 1, v);

        // random traffic
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 3) != 0) begin
                v = {1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255))};
                push_cmd(v, ok);
            end else begin
                rd_reg(2'd1, 0, v);
                if (v[3]) pop_check("R3 random pop");
            end
        end
        push_force(10'h2AA);
        drain_idle();
        rd_reg(2'd2, 0, v); chk("R6 stop after random traffic", int'(v[0]), 1);

        // R1 ordering and count
        chk("R1 transfer count", n_got, n_exp);
        for (int k = 0; k < n_exp; k++) chk("R1 entry order", int'(got_cmd[k]), int'(exp_cmd[k]));
        chk("R3 all bytes read", n_rxrd, n_exprx);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule